// File: doc/BRIEF.md
# Dual-source serial baud tick generator

This block feeds a serial port with two single-cycle enable pulses, `tx_tick` and `rx_tick`, each at sixteen times the bit rate of its direction. Two auto-reload timers can produce the pulses. The first is an 8-bit timer. It runs either at the system clock or at a twelfth of it, and a rate-doubler bit picks whether every overflow or every second overflow becomes a tick. The second is a 16-bit timer that acts only as a baud generator. It counts at half the system clock and gives one tick per overflow.

Each direction picks its timer with its own select bit, so transmit and receive can run at different rates. The 16-bit timer counts only while at least one direction selects it. Both timers roll over from all ones and then reload from their reload inputs. A new reload value therefore takes effect at the next overflow. While reset is active the timers are loaded with their reload values.

Top module: `baud_pair_gen`

## Requirements
- R1: While `rst_n` is low, both ticks stay 0 and each timer is loaded with its reload value. With `fast8`=1, `dbl`=1 and `reload8`=0xFC, the first 8-bit tick is seen on the 4th clock edge after reset is released.
- R2: When `fast8`=1 the 8-bit timer counts once per clock, rolls over from 0xFF and reloads from `reload8`, so it overflows every 256−`reload8` cycles (1 cycle when `reload8`=0xFF).
- R3: When `fast8`=0 the 8-bit timer counts once every 12 clocks, so its overflow interval is 12×(256−`reload8`) cycles.
- R4: On the 8-bit path, `dbl`=1 gives a tick on every overflow. `dbl`=0 gives a tick on every second overflow, and after reset the first overflow gives none.
- R5: A direction whose select bit is 1 receives one tick per 16-bit overflow, which is every 2×(65536−`reload16`) cycles.
- R6: `tx_sel16` chooses the source of `tx_tick` and `rx_sel16` chooses the source of `rx_tick` independently (1 = 16-bit timer, 0 = 8-bit timer). Directions with equal selects see identical ticks.
- R7: `dbl` and `fast8` do not change the 16-bit path. The 16-bit timer holds its value while both select bits are 0.
- R8: A reload value changed while a timer runs does not change the interval already under way. It applies from the next overflow onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reload8 | input | CNT8_W | Reload value of the 8-bit timer |
| reload16 | input | CNT16_W | Reload value of the 16-bit timer |
| fast8 | input | 1 | 1: 8-bit timer counts every clock; 0: every 12th clock |
| dbl | input | 1 | Rate doubler for the 8-bit path |
| tx_sel16 | input | 1 | Transmit source, 1 = 16-bit timer |
| rx_sel16 | input | 1 | Receive source, 1 = 16-bit timer |
| tx_tick | output | 1 | Transmit 16x oversample enable pulse |
| rx_tick | output | 1 | Receive 16x oversample enable pulse |

## Verification
The tick interval is measured on both outputs under a table of settings. The table covers every combination of prescale and doubler on the 8-bit path, each mixed setting of the two select bits, and the 16-bit path with the doubler and prescale bits toggled. A wrong prescale factor, a missing or extra divide-by-two, or a swapped direction select each gives a different interval. A reload of 0xFF gives a tick on every cycle, and a reload of zero gives the longest 8-bit interval; together they show that the rollover point is right. Directed runs fix the first tick after reset and show that a mid-run reload change leaves the current interval alone.

// File: rtl/baud_pair_gen.sv
module baud_pair_gen #(
  parameter int CNT8_W   = 8,
  parameter int CNT16_W  = 16,
  parameter int PRESCALE = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT8_W-1:0]  reload8,
  input  logic [CNT16_W-1:0] reload16,
  input  logic               fast8,
  input  logic               dbl,
  input  logic               tx_sel16,
  input  logic               rx_sel16,
  output logic               tx_tick,
  output logic               rx_tick
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0]   pre;
  logic [CNT8_W-1:0]  t8;
  logic [CNT16_W-1:0] t16;
  logic half, ph;
  logic en8, en16, run16, ov8, ov16, tick8;

  assign en8   = fast8 | (pre == PRE_LAST);
  assign run16 = tx_sel16 | rx_sel16;
  assign en16  = run16 & ph;
  assign ov8   = en8 & (&t8);
  assign ov16  = en16 & (&t16);
  assign tick8 = ov8 & (dbl | half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre     <= '0;
      t8      <= reload8;
      t16     <= reload16;
      half    <= 1'b0;
      ph      <= 1'b0;
      tx_tick <= 1'b0;
      rx_tick <= 1'b0;
    end else begin
      pre  <= (pre == PRE_LAST) ? '0 : pre + 1'b1;
      if (en8)  t8  <= ov8  ? reload8  : t8 + 1'b1;
      if (en16) t16 <= ov16 ? reload16 : t16 + 1'b1;
      half    <= half ^ ov8;
      ph      <= run16 & ~ph;
      tx_tick <= tx_sel16 ? ov16 : tick8;
      rx_tick <= rx_sel16 ? ov16 : tick8;
    end
  end
endmodule

// File: rtl/baud_pair_gen_chk.sv
module baud_pair_gen_chk #(
  parameter int CNT8_W  = 8,
  parameter int CNT16_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [CNT8_W-1:0]  reload8,
  input logic [CNT16_W-1:0] reload16,
  input logic               dbl,
  input logic               tx_sel16,
  input logic               rx_sel16,
  input logic               ov8,
  input logic               ov16,
  input logic [CNT8_W-1:0]  t8,
  input logic [CNT16_W-1:0] t16,
  input logic               tx_tick,
  input logic               rx_tick
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tx_tick && !rx_tick));

  a_r2_reload8_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ov8 |=> (t8 == $past(reload8)));

  a_r4_dbl_every_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (ov8 && dbl && !tx_sel16) |=> tx_tick);

  a_r4_no_tick_without_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (!ov8 && !tx_sel16) |=> !tx_tick);

  a_r5_reload16_on_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    ov16 |=> (t16 == $past(reload16)));

  a_r5_tick_from_ovf16: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_sel16 && ov16) |=> rx_tick);

  a_r6_equal_selects: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_sel16 == rx_sel16) |=> (tx_tick == rx_tick));

  a_r7_idle16_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_sel16 && !rx_sel16) |=> $stable(t16));
endmodule

bind baud_pair_gen baud_pair_gen_chk #(.CNT8_W(CNT8_W), .CNT16_W(CNT16_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reload8(reload8), .reload16(reload16), .dbl(dbl),
  .tx_sel16(tx_sel16), .rx_sel16(rx_sel16), .ov8(ov8), .ov16(ov16),
  .t8(t8), .t16(t16), .tx_tick(tx_tick), .rx_tick(rx_tick)
);

// File: tb/sim_baud_pair_gen.sv
module sim_baud_pair_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] reload8 = 8'hF0;
  logic [15:0] reload16 = 16'hFF00;
  logic fast8 = 1'b1, dbl = 1'b1, tx_sel16 = 1'b0, rx_sel16 = 1'b0;
  logic tx_tick, rx_tick;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  baud_pair_gen u0 (.clk(clk), .rst_n(rst_n), .reload8(reload8), .reload16(reload16),
    .fast8(fast8), .dbl(dbl), .tx_sel16(tx_sel16), .rx_sel16(rx_sel16),
    .tx_tick(tx_tick), .rx_tick(rx_tick));

  // {fast8, dbl, tx_sel16, rx_sel16, reload8, reload16}
  localparam int NV = 9;
  localparam logic [27:0] VEC [NV] = '{
    {4'b1100, 8'hF0, 16'hFF00},  // R2 R4
    {4'b1000, 8'hE0, 16'hFF00},  // R4
    {4'b0100, 8'hF8, 16'hFF00},  // R3
    {4'b0010, 8'hF0, 16'hFF80},  // R5 R6
    {4'b1101, 8'hC0, 16'hFFF0},  // R6
    {4'b0011, 8'h00, 16'hFFE0},  // R7
    {4'b1111, 8'h80, 16'hFF00},  // R7
    {4'b1100, 8'hFF, 16'hFF00},  // R2 boundary
    {4'b0000, 8'h00, 16'hFF00}   // R3 boundary
  };

  function automatic string tag_of(int i);
    case (i)
      0: return "R2";  1: return "R4";  2: return "R3";  3: return "R5";
      4: return "R6";  5: return "R7";  6: return "R7";  7: return "R2";
      default: return "R3";
    endcase
  endfunction

  function automatic int exp_gap(bit sel16, bit f, bit d, logic [7:0] r8, logic [15:0] r16);
    if (sel16) return 2 * (65536 - int'(r16));
    return (f ? 1 : 12) * (256 - int'(r8)) * (d ? 1 : 2);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic next_gap(bit use_rx, output int gap);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(use_rx ? rx_tick : tx_tick) && n < 20000);
    gap = n;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int g;
    // R1: quiet during reset, first tick 4 edges after release
    fast8 = 1; dbl = 1; reload8 = 8'hFC; tx_sel16 = 0; rx_sel16 = 0;
    repeat (5) @(negedge clk);
    chk("R1 tx during reset", int'(tx_tick), 0);
    chk("R1 rx during reset", int'(rx_tick), 0);
    rst_n = 1'b1;
    next_gap(0, g);
    chk("R1 first tick", g, 4);

    // R4: no doubler, first overflow skipped
    dbl = 0;
    do_reset();
    next_gap(0, g);
    chk("R4 first tick without doubler", g, 8);

    // R8: reload change applies from the next overflow
    dbl = 1; reload8 = 8'hF0;
    do_reset();
    next_gap(0, g);
    next_gap(0, g);
    reload8 = 8'hE0;
    next_gap(0, g);
    chk("R8 interval in progress", g, 16);
    next_gap(0, g);
    chk("R8 interval after overflow", g, 32);

    for (int i = 0; i < NV; i++) begin
      int gt, gr;
      {fast8, dbl, tx_sel16, rx_sel16, reload8, reload16} = VEC[i];
      do_reset();
      next_gap(0, gt);
      next_gap(0, gt);
      next_gap(1, gr);
      next_gap(1, gr);
      chk({tag_of(i), " tx interval"}, gt, exp_gap(tx_sel16, fast8, dbl, reload8, reload16));
      chk({tag_of(i), " rx interval"}, gr, exp_gap(rx_sel16, fast8, dbl, reload8, reload16));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule